// File: doc/BRIEF.md
# Per-Page Memory Bank Selector

This block lets an 8-bit processor system with two 64 KB RAM blocks choose, one 16 KB page at a time, which physical block answers each memory access. The 64 KB map is split into four pages by the two top address bits. A 4-bit mapping register holds one bit per page. The processor loads that register with an I/O output instruction to port 3.

On every memory access, the block looks up the register bit for the addressed page. It then pulls low the chip select of block 1 (bit clear) or of block 2 (bit set). Each chip select also enables the output drivers of its RAM block, so the two selects are never low together. Both selects stay high outside memory requests and during I/O cycles.

The port decode has two variants, chosen by a parameter. The partial variant compares only the low port address bits. The full variant compares all eight bits, and it also raises an indication that an external I/O device has been addressed.

Top module: `bank_page_sel`

## Requirements
- R1: After reset the mapping register is 0, so every page is routed to block 1.
- R2: A cycle with `io_req` and `io_wr` high to the matching port loads `io_data[3:0]` into the mapping register at that clock edge. Bit n of the register controls page n. `io_data[7:4]` is ignored. The new mapping applies from the next cycle.
- R3: With full decode, a write to any port number other than 3 leaves the mapping unchanged.
- R4: With partial decode, only the low `MATCH_BITS` (default 2) bits of the port number are compared. Port 0x07, for example, loads the register.
- R5: With full decode, `ext_io_sel` is high exactly when `io_req` is high and `io_port` equals 3. With partial decode it stays low.
- R6: The page index is `mem_addr[15:14]`. When the register bit for that page is 0, `blk1_cs_n` goes low and `blk2_cs_n` stays high.
- R7: When the register bit for the addressed page is 1, `blk2_cs_n` goes low and `blk1_cs_n` stays high.
- R8: Both chip selects are high whenever `mem_req` is low or `io_req` is high.
- R9: `blk1_cs_n` and `blk2_cs_n` are never low at the same time.
- R10: An I/O cycle to port 3 with `io_wr` low (a read) does not change the mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | I/O cycle in progress |
| io_wr | input | 1 | Write strobe of the I/O cycle |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | Data bus during the I/O write |
| mem_req | input | 1 | Memory request active |
| mem_addr | input | 16 | Memory address |
| blk1_cs_n | output | 1 | Active-low select of RAM block 1 |
| blk2_cs_n | output | 1 | Active-low select of RAM block 2 |
| ext_io_sel | output | 1 | External I/O indication (full decode only) |

## Verification
The hardest case to reach from the ports is a page whose register bit differs from the bits of the pages next to it. A uniform mapping cannot expose a swapped page index or a reversed bit order. The bench therefore loads mixed patterns such as 0x3, 0x5 and 0xA, and after each load it sweeps all four pages. It also applies the partial-decode alias port and the non-matching ports while a non-zero mapping is held, so that a write that should be ignored would show up as a changed chip select.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;

  // Compare the low 'bits' bits of a port number with a target port.
  function automatic logic port_match(input logic [7:0] port,
                                      input logic [7:0] target,
                                      input int unsigned bits);
    logic ok;
    ok = 1'b1;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < bits && port[i] != target[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Block choice for one access: 1 selects block 2, 0 selects block 1.
  function automatic logic pick_block(input logic [3:0] map,
                                      input logic [1:0] page);
    return map[page];
  endfunction

endpackage

// File: rtl/bsel_port_decode.sv
module bsel_port_decode #(
  parameter int unsigned PORT_NUM    = 3,
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned MATCH_BITS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_req,
  input  logic [7:0] io_port,
  output logic       port_hit,
  output logic       ext_sel
);
  import bank_sel_pkg::*;

  localparam logic [7:0] TARGET = PORT_NUM[7:0];

  generate
    if (FULL_DECODE) begin : g_full
      assign port_hit = port_match(io_port, TARGET, 8);
      assign ext_sel  = io_req & port_hit;
    end else begin : g_part
      assign port_hit = port_match(io_port, TARGET, MATCH_BITS);
      assign ext_sel  = 1'b0;

      AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel); // R5
    end
  endgenerate

endmodule

// File: rtl/bsel_page_reg.sv
module bsel_page_reg #(
  parameter int unsigned NUM_PAGES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_hit,
  input  logic [NUM_PAGES-1:0] wr_data,
  output logic [NUM_PAGES-1:0] map_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (wr_hit) map_q <= wr_data;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hit)) |-> map_q == $past(wr_data)); // R2
  AST_HOLD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_hit)) |-> $stable(map_q)); // R3

endmodule

// File: rtl/bsel_cs_steer.sv
module bsel_cs_steer #(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PAGE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 access,
  input  logic [NUM_PAGES-1:0] map_q,
  input  logic [PAGE_BITS-1:0] page_idx,
  output logic                 cs1_n,
  output logic                 cs2_n
);

  logic to_blk2;
  assign to_blk2 = map_q[page_idx];
  assign cs1_n   = ~(access & ~to_blk2);
  assign cs2_n   = ~(access &  to_blk2);

  AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n | cs2_n); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (cs1_n && cs2_n)); // R8
  AST_ROUTE_B1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1_n |-> !map_q[page_idx]); // R6
  AST_ROUTE_B2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs2_n |-> map_q[page_idx]); // R7

endmodule

// File: rtl/bank_page_sel.sv
module bank_page_sel #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PAGE_BITS   = 2,
  parameter int unsigned PORT_NUM    = 3,
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned MATCH_BITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [7:0]        io_port,
  input  logic [7:0]        io_data,
  input  logic              mem_req,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              blk1_cs_n,
  output logic              blk2_cs_n,
  output logic              ext_io_sel
);

  localparam int unsigned NUM_PAGES = 1 << PAGE_BITS;

  logic                 port_hit;
  logic                 wr_hit;
  logic                 access;
  logic [NUM_PAGES-1:0] map_q;
  logic [PAGE_BITS-1:0] page_idx;

  assign wr_hit   = io_req & io_wr & port_hit;
  assign access   = mem_req & ~io_req;
  assign page_idx = mem_addr[ADDR_W-1 -: PAGE_BITS];

  bsel_port_decode #(
    .PORT_NUM(PORT_NUM), .FULL_DECODE(FULL_DECODE), .MATCH_BITS(MATCH_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_port(io_port),
    .port_hit(port_hit), .ext_sel(ext_io_sel)
  );

  bsel_page_reg #(.NUM_PAGES(NUM_PAGES)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wr_data(io_data[NUM_PAGES-1:0]), .map_q(map_q)
  );

  bsel_cs_steer #(.NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS)) u_cs (
    .clk(clk), .rst_n(rst_n), .access(access), .map_q(map_q),
    .page_idx(page_idx), .cs1_n(blk1_cs_n), .cs2_n(blk2_cs_n)
  );

  AST_READ_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(io_req) && !$past(io_wr)) |-> $stable(map_q)); // R10
  AST_IO_BLOCKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (blk1_cs_n && blk2_cs_n)); // R8

endmodule

// File: tb/bank_page_sel_bench.sv
module bank_page_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0, mem_req = 1'b0;
  logic [7:0]  io_port = '0, io_data = '0;
  logic [15:0] mem_addr = '0;
  logic        cs1_n, cs2_n, ext_sel;
  logic        p_cs1_n, p_cs2_n, p_ext;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bank_page_sel u_bank_page_sel (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
    .io_port(io_port), .io_data(io_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .blk1_cs_n(cs1_n), .blk2_cs_n(cs2_n),
    .ext_io_sel(ext_sel)
  );

  bank_page_sel #(.FULL_DECODE(1'b0)) u_bank_page_sel_part (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
    .io_port(io_port), .io_data(io_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .blk1_cs_n(p_cs1_n), .blk2_cs_n(p_cs2_n),
    .ext_io_sel(p_ext)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // I/O cycle lasting one clock; ext indication sampled mid-cycle.
  task automatic io_cycle(input logic wr, input logic [7:0] port, input logic [7:0] data,
                          input logic exp_ext, input logic exp_pext);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_port = port; io_data = data;
    mem_req = 1'b1;
    #1;
    chk("R5 ext_io_sel full", {7'b0, ext_sel}, {7'b0, exp_ext});
    chk("R5 ext_io_sel partial", {7'b0, p_ext}, {7'b0, exp_pext});
    chk("R8 cs idle in io cycle", {6'b0, cs1_n, cs2_n}, 8'h03);
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0; mem_req = 1'b0;
  endtask

  // Sweep all pages; map bit n = 1 means block 2 (blk2_cs_n low).
  task automatic sweep(input string req, input logic [3:0] m_full, input logic [3:0] m_part);
    for (int pg = 0; pg < 4; pg++) begin
      @(negedge clk);
      mem_req = 1'b1;
      mem_addr = {pg[1:0], 14'h1A5 + 14'(pg)};
      #1;
      chk(req, {6'b0, cs1_n, cs2_n}, m_full[pg] ? 8'h02 : 8'h01);
      chk(req, {6'b0, p_cs1_n, p_cs2_n}, m_part[pg] ? 8'h02 : 8'h01);
      chk("R9 exclusive", {7'b0, cs1_n | cs2_n}, 8'h01);
    end
    @(negedge clk);
    mem_req = 1'b0;
    #1;
    chk("R8 idle no mem_req", {6'b0, cs1_n, cs2_n}, 8'h03);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 cs during reset idle", {6'b0, cs1_n, cs2_n}, 8'h03);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset map all block 1", 4'h0, 4'h0);
  endtask

  task automatic t_loads();
    io_cycle(1'b1, 8'h03, 8'hA3, 1'b1, 1'b0);
    sweep("R2 R6 R7 load 0x3", 4'h3, 4'h3);
    io_cycle(1'b1, 8'h03, 8'h05, 1'b1, 1'b0);
    sweep("R2 R6 R7 load 0x5", 4'h5, 4'h5);
    io_cycle(1'b1, 8'h03, 8'h0F, 1'b1, 1'b0);
    sweep("R7 load 0xF", 4'hF, 4'hF);
    io_cycle(1'b1, 8'h03, 8'hF0, 1'b1, 1'b0);
    sweep("R6 load 0x0", 4'h0, 4'h0);
    io_cycle(1'b1, 8'h03, 8'h0A, 1'b1, 1'b0);
    sweep("R2 load 0xA", 4'hA, 4'hA);
  endtask

  task automatic t_decode();
    io_cycle(1'b1, 8'h07, 8'h06, 1'b0, 1'b0);
    sweep("R3 R4 alias port 0x07", 4'hA, 4'h6);
    io_cycle(1'b1, 8'h13, 8'h09, 1'b0, 1'b0);
    sweep("R3 R4 alias port 0x13", 4'hA, 4'h9);
    io_cycle(1'b1, 8'h02, 8'h0F, 1'b0, 1'b0);
    sweep("R3 port 0x02 ignored", 4'hA, 4'h9);
  endtask

  task automatic t_read();
    io_cycle(1'b0, 8'h03, 8'h0F, 1'b1, 1'b0);
    sweep("R10 read ignored", 4'hA, 4'h9);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_decode();
    t_read();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule